// File: doc/BRIEF.md
# 32-Point Radix-2 Decimation-in-Frequency FFT Engine

This block computes a 32-point discrete Fourier transform of complex 16-bit fixed-point samples. A host sends a start pulse while the engine is idle. It then streams 32 samples in natural time order, and the engine accepts one sample per cycle on which `in_valid` is high. A single shared butterfly then works in place on an internal register file. It runs five decimation-in-frequency stages of sixteen butterflies each, one butterfly per cycle, and each stage works on the results of the stage before it.

The final stage leaves its spectrum in bit-reversed slot order. The engine unloads it in natural frequency order by reading each slot at the bit-reversed address. It presents the bins on 32 consecutive cycles with a valid strobe and the bin index, and then raises a one-cycle completion pulse. Each stage halves its results, so the output equals the DFT divided by 32. Twiddle factors are Q1.14 constants derived from a nine-entry quarter-wave table.

The controller has five named states. IDLE goes to FILL on a start pulse. FILL goes to CRUNCH once the 32nd sample is taken. CRUNCH goes to DRAIN after butterfly 15 of stage 4. DRAIN goes to FINISH after bin 31. FINISH returns to IDLE unconditionally.

Top module: `fft32_dif`

## Requirements
- R1: While reset is held and after it is released, `out_valid`, `done` and `load_ready` are 0 and the engine sits in IDLE.
- R2: `start` is acted on only in IDLE. The cycle after an accepted start, `load_ready` is 1. A start pulse in any other state changes nothing: `load_ready` stays 0 and the frame in progress completes unchanged.
- R3: In FILL, each cycle with `in_valid` high stores one sample at the next natural index, from 0 to 31. Cycles with `in_valid` low may come between samples. `in_valid` is ignored outside FILL. `load_ready` drops the cycle after the 32nd sample is taken.
- R4: The computation takes exactly 80 cycles, which is 5 stages of 16 butterflies. The first output is visible 81 cycles after the clock edge that takes the 32nd sample.
- R5: In stage s, from 0 to 4, the butterfly partners are 16>>s apart and the twiddle index is (j<<s) mod 16, where j is the offset inside the group. The upper result is (a+b)>>1. The lower result is ((a-b)·W)>>1, where W = cos(2πk/32) − j·sin(2πk/32) in Q1.14.
- R6: For inputs whose parts stay within ±8192, bin k equals (1/32)·Σ x[n]·e^(−j2πkn/32) within ±4 LSB on each part.
- R7: The engine asserts `out_valid` for exactly 32 consecutive cycles. `out_idx` runs 0,1,…,31 in natural frequency order.
- R8: `done` is a single-cycle pulse in the cycle right after the last `out_valid`. The engine is then back in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (honoured only in IDLE) |
| in_valid | input | 1 | Sample strobe during FILL |
| in_re | input | 16 | Sample real part, signed |
| in_im | input | 16 | Sample imaginary part, signed |
| load_ready | output | 1 | High while the engine takes samples |
| out_valid | output | 1 | Bin strobe |
| out_idx | output | 5 | Frequency index of the presented bin |
| out_re | output | 16 | Bin real part, signed, scaled by 1/32 |
| out_im | output | 16 | Bin imaginary part, signed, scaled by 1/32 |
| done | output | 1 | One-cycle frame completion pulse |

## Verification
`load_ready` is due one cycle after the start edge, and it drops one cycle after the 32nd sample. The first bin appears exactly 81 cycles after the edge that takes the last sample. The next bins follow on consecutive cycles, and `done` comes one cycle after bin 31. The bench drives inputs and samples all outputs at falling edges. It logs the cycle of the last sample and compares the cycle of the first bin with that count plus 81. The scoreboard pops one expected bin for every strobe it sees, so a late, early, missing or extra bin turns up as a mismatch.

// File: rtl/fft32_pkg.sv
package fft32_pkg;
    localparam int LOG2_N  = 5;
    localparam int N       = 1 << LOG2_N;
    localparam int DATA_W  = 16;
    localparam int TW_FRAC = 14;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_CRUNCH,
        ST_DRAIN,
        ST_FINISH
    } fsm_t;

    // quarter-wave table: round(2^14 * cos(m * 2*pi/32)), m = 0..8
    function automatic logic signed [DATA_W-1:0] quarter(input logic [3:0] m);
        unique case (m)
            4'd0:    quarter = 16'sd16384;
            4'd1:    quarter = 16'sd16069;
            4'd2:    quarter = 16'sd15137;
            4'd3:    quarter = 16'sd13623;
            4'd4:    quarter = 16'sd11585;
            4'd5:    quarter = 16'sd9102;
            4'd6:    quarter = 16'sd6270;
            4'd7:    quarter = 16'sd3196;
            default: quarter = 16'sd0;
        endcase
    endfunction

    function automatic logic signed [DATA_W-1:0] tw_cos(input logic [3:0] k);
        if (k <= 4'd8) tw_cos = quarter(k);
        else           tw_cos = -quarter(4'd0 - k);
    endfunction

    // imaginary part of W = -sin
    function automatic logic signed [DATA_W-1:0] tw_nsin(input logic [3:0] k);
        if (k <= 4'd8) tw_nsin = -quarter(4'd8 - k);
        else           tw_nsin = -quarter(k - 4'd8);
    endfunction
endpackage

// File: rtl/fft32_cmul.sv
module fft32_cmul #(
    parameter int DW = 16,
    parameter int WW = 16
) (
    input  logic signed [DW-1:0]      x_re,
    input  logic signed [DW-1:0]      x_im,
    input  logic signed [WW-1:0]      w_re,
    input  logic signed [WW-1:0]      w_im,
    output logic signed [DW+WW:0]     p_re,
    output logic signed [DW+WW:0]     p_im
);
    assign p_re = x_re * w_re - x_im * w_im;
    assign p_im = x_re * w_im + x_im * w_re;
endmodule

// File: rtl/fft32_butterfly.sv
module fft32_butterfly #(
    parameter int DW = 16,
    parameter int TF = 14
) (
    input  logic signed [DW-1:0] a_re,
    input  logic signed [DW-1:0] a_im,
    input  logic signed [DW-1:0] b_re,
    input  logic signed [DW-1:0] b_im,
    input  logic signed [DW-1:0] w_re,
    input  logic signed [DW-1:0] w_im,
    output logic signed [DW-1:0] up_re,
    output logic signed [DW-1:0] up_im,
    output logic signed [DW-1:0] lo_re,
    output logic signed [DW-1:0] lo_im
);
    localparam int XW = DW + 1;
    localparam int PW = XW + DW + 1;

    logic signed [XW-1:0] sum_re, sum_im, dif_re, dif_im;
    logic signed [PW-1:0] prod_re, prod_im;

    assign sum_re = a_re + b_re;
    assign sum_im = a_im + b_im;
    assign dif_re = a_re - b_re;
    assign dif_im = a_im - b_im;

    fft32_cmul #(.DW(XW), .WW(DW)) u_cmul (
        .x_re(dif_re), .x_im(dif_im),
        .w_re(w_re),   .w_im(w_im),
        .p_re(prod_re), .p_im(prod_im)
    );

    // per-stage halving folded into the slices
    assign up_re = sum_re[XW-1:1];
    assign up_im = sum_im[XW-1:1];
    assign lo_re = prod_re[DW+TF:TF+1];
    assign lo_im = prod_im[DW+TF:TF+1];

    logic unused_bits;
    assign unused_bits = ^{sum_re[0], sum_im[0], prod_re[PW-1:DW+TF+1], prod_re[TF:0],
                           prod_im[PW-1:DW+TF+1], prod_im[TF:0]};
endmodule

// File: rtl/fft32_addr_gen.sv
module fft32_addr_gen #(
    parameter int LOG2_N = 5,
    localparam int SW = $clog2(LOG2_N)
) (
    input  logic [SW-1:0]     stage,
    input  logic [LOG2_N-2:0] bfly,
    output logic [LOG2_N-1:0] top_addr,
    output logic [LOG2_N-1:0] bot_addr,
    output logic [LOG2_N-2:0] tw_idx
);
    logic [LOG2_N-1:0] b_ext, half, offs, grp, tw_full;
    int unsigned        sh;

    always_comb begin
        sh       = LOG2_N - 1 - int'(stage);
        b_ext    = {1'b0, bfly};
        half     = LOG2_N'(1) << sh;
        offs     = b_ext & (half - LOG2_N'(1));
        grp      = b_ext >> sh;
        top_addr = (grp << (sh + 1)) | offs;
        bot_addr = top_addr | half;
        tw_full  = offs << stage;
        tw_idx   = tw_full[LOG2_N-2:0];
    end

    logic unused_tw;
    assign unused_tw = tw_full[LOG2_N-1];
endmodule

// File: rtl/fft32_dif.sv
module fft32_dif
    import fft32_pkg::*;
#(
    parameter int DW = fft32_pkg::DATA_W,
    parameter int TF = fft32_pkg::TW_FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    in_valid,
    input  logic signed [DW-1:0]    in_re,
    input  logic signed [DW-1:0]    in_im,
    output logic                    load_ready,
    output logic                    out_valid,
    output logic [LOG2_N-1:0]       out_idx,
    output logic signed [DW-1:0]    out_re,
    output logic signed [DW-1:0]    out_im,
    output logic                    done
);
    localparam int SW = $clog2(LOG2_N);
    localparam int BW = LOG2_N - 1;
    localparam logic [LOG2_N-1:0] LAST_IDX  = LOG2_N'(N - 1);
    localparam logic [BW-1:0]     LAST_BF   = '1;
    localparam logic [SW-1:0]     LAST_STG  = SW'(LOG2_N - 1);

    fsm_t               state;
    logic [LOG2_N-1:0]  cnt;
    logic [SW-1:0]      stg;
    logic [BW-1:0]      bfl;

    logic signed [DW-1:0] mem_re [N];
    logic signed [DW-1:0] mem_im [N];

    logic [LOG2_N-1:0]    top_a, bot_a, rev_cnt;
    logic [BW-1:0]        tw_k;
    logic signed [DW-1:0] w_re, w_im, up_re, up_im, lo_re, lo_im;

    fft32_addr_gen #(.LOG2_N(LOG2_N)) u_addr (
        .stage(stg), .bfly(bfl),
        .top_addr(top_a), .bot_addr(bot_a), .tw_idx(tw_k)
    );

    assign w_re = tw_cos(tw_k);
    assign w_im = tw_nsin(tw_k);

    fft32_butterfly #(.DW(DW), .TF(TF)) u_bfly (
        .a_re(mem_re[top_a]), .a_im(mem_im[top_a]),
        .b_re(mem_re[bot_a]), .b_im(mem_im[bot_a]),
        .w_re(w_re), .w_im(w_im),
        .up_re(up_re), .up_im(up_im),
        .lo_re(lo_re), .lo_im(lo_im)
    );

    for (genvar g = 0; g < LOG2_N; g++) begin : g_rev
        assign rev_cnt[g] = cnt[LOG2_N-1-g];
    end

    // state register and sequencing counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            stg   <= '0;
            bfl   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    cnt <= '0;
                    if (start) state <= ST_FILL;
                end
                ST_FILL: begin
                    if (in_valid) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_IDX) begin
                            state <= ST_CRUNCH;
                            stg   <= '0;
                            bfl   <= '0;
                        end
                    end
                end
                ST_CRUNCH: begin
                    bfl <= bfl + 1'b1;
                    if (bfl == LAST_BF) begin
                        stg <= stg + 1'b1;
                        if (stg == LAST_STG) begin
                            state <= ST_DRAIN;
                            cnt   <= '0;
                        end
                    end
                end
                ST_DRAIN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == LAST_IDX) state <= ST_FINISH;
                end
                ST_FINISH: state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // working memory: sample load and in-place butterfly write-back
    always_ff @(posedge clk) begin
        if (state == ST_FILL && in_valid) begin
            mem_re[cnt] <= in_re;
            mem_im[cnt] <= in_im;
        end else if (state == ST_CRUNCH) begin
            mem_re[top_a] <= up_re;
            mem_im[top_a] <= up_im;
            mem_re[bot_a] <= lo_re;
            mem_im[bot_a] <= lo_im;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_idx   <= '0;
            out_re    <= '0;
            out_im    <= '0;
            done      <= 1'b0;
        end else begin
            out_valid <= (state == ST_DRAIN);
            out_idx   <= cnt;
            out_re    <= mem_re[rev_cnt];
            out_im    <= mem_im[rev_cnt];
            done      <= (state == ST_FINISH);
        end
    end

    assign load_ready = (state == ST_FILL);
endmodule

// File: rtl/fft32_dif_chk.sv
module fft32_dif_chk #(
    parameter int LOG2_N = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              load_ready,
    input logic              out_valid,
    input logic [LOG2_N-1:0] out_idx,
    input logic              done
);
    localparam int RUN_W = LOG2_N + 1;
    logic [RUN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (!rst_n)         run <= '0;
        else if (out_valid) run <= run + 1'b1;
        else                run <= '0;
    end

    a_r7_first_bin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_idx == '0);

    a_r7_bin_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> out_idx == $past(out_idx) + 1'b1);

    a_r7_run_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> run == RUN_W'(1 << LOG2_N));

    a_r8_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> done);

    a_r8_done_place: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!out_valid && $past(out_valid)));

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r2_fill_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        load_ready |-> (!out_valid && !done));
endmodule

bind fft32_dif fft32_dif_chk #(.LOG2_N(fft32_pkg::LOG2_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_ready(load_ready),
    .out_valid(out_valid), .out_idx(out_idx), .done(done)
);

// File: tb/fft32_dif_bench.sv
module fft32_dif_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NPT = 32;
    localparam int TOL = 4;
    localparam real PI = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic in_valid = 1'b0;
    logic signed [15:0] in_re = '0, in_im = '0;
    logic load_ready, out_valid, done;
    logic [4:0] out_idx;
    logic signed [15:0] out_re, out_im;

    fft32_dif u_fft32_dif (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_re(in_re), .in_im(in_im), .load_ready(load_ready),
        .out_valid(out_valid), .out_idx(out_idx),
        .out_re(out_re), .out_im(out_im), .done(done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { int re; int im; int idx; } bin_t;
    bin_t exp_q[$];

    int checks = 0, errors = 0;
    int cyc = 0, last_acc = 0, frames_done = 0, run = 0;
    bit prev_valid = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid) begin
                if (run == 0)
                    chk(cyc == last_acc + 81, "R4", "first bin cycle", cyc, last_acc + 81);
                if (exp_q.size() == 0) begin
                    chk(0, "R7", "unexpected bin", int'(out_idx), -1);
                end else begin
                    bin_t e;
                    e = exp_q.pop_front();
                    chk(int'(out_idx) == e.idx, "R7", "bin index", int'(out_idx), e.idx);
                    chk((int'(out_re) - e.re <= TOL) && (e.re - int'(out_re) <= TOL),
                        "R6", "bin real", int'(out_re), e.re);
                    chk((int'(out_im) - e.im <= TOL) && (e.im - int'(out_im) <= TOL),
                        "R6", "bin imag", int'(out_im), e.im);
                end
                run++;
            end
            if (done) begin
                chk(prev_valid && !out_valid, "R8", "done right after last bin", int'(prev_valid), 1);
                chk(run == NPT, "R7", "bins per frame", run, NPT);
                run = 0;
                frames_done++;
            end else if (prev_valid && !out_valid) begin
                chk(0, "R8", "done missing after last bin", 0, 1);
            end
            prev_valid = out_valid;
        end
    end

    // driver: builds a frame, pushes expected bins, streams samples
    task automatic run_frame(input int kind, input bit gaps, input bit disturb);
        int xr[NPT];
        int xi[NPT];
        int target;
        for (int n = 0; n < NPT; n++) begin
            xr[n] = 0; xi[n] = 0;
            case (kind)
                0: if (n == 0) xr[n] = 8000;
                1: begin xr[n] = 1000; xi[n] = -500; end
                2: begin
                    xr[n] = int'(4000.0 * $cos(2.0 * PI * 3.0 * n / NPT));
                    xi[n] = int'(4000.0 * $sin(2.0 * PI * 3.0 * n / NPT));
                end
                default: if (n == 5) begin xr[n] = 6400; xi[n] = -3200; end
            endcase
        end
        for (int k = 0; k < NPT; k++) begin
            real ar, ai;
            bin_t b;
            ar = 0.0; ai = 0.0;
            for (int n = 0; n < NPT; n++) begin
                real ang;
                ang = -2.0 * PI * k * n / NPT;
                ar += xr[n] * $cos(ang) - xi[n] * $sin(ang);
                ai += xr[n] * $sin(ang) + xi[n] * $cos(ang);
            end
            b.re = int'(ar / NPT); b.im = int'(ai / NPT); b.idx = k;
            exp_q.push_back(b);
        end
        target = frames_done + 1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(load_ready == 1'b1, "R2", "load_ready after start", int'(load_ready), 1);
        for (int n = 0; n < NPT; n++) begin
            if (gaps && (n % 3 == 1)) begin
                in_valid = 1'b0; in_re = 16'sh7FFF; in_im = 16'sh7FFF;
                @(negedge clk);
            end
            in_valid = 1'b1; in_re = 16'(xr[n]); in_im = 16'(xi[n]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        last_acc = cyc;
        chk(load_ready == 1'b0, "R3", "load_ready after 32 samples", int'(load_ready), 0);
        if (disturb) begin
            repeat (5) @(negedge clk);
            start = 1'b1; in_valid = 1'b1; in_re = 16'sh1234; in_im = -16'sh0777;
            @(negedge clk);
            start = 1'b0; in_valid = 1'b0;
            chk(load_ready == 1'b0, "R2", "start ignored while busy", int'(load_ready), 0);
        end
        while (frames_done < target) @(negedge clk);
        @(negedge clk);
        chk(load_ready == 1'b0 && out_valid == 1'b0, "R8", "idle after done",
            int'(load_ready) + int'(out_valid), 0);
    endtask

    initial begin
        fork
            begin
                repeat (100000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        chk(out_valid == 0 && done == 0 && load_ready == 0, "R1", "outputs in reset",
            int'(out_valid) + int'(done) + int'(load_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 0 && done == 0 && load_ready == 0, "R1", "outputs after reset",
            int'(out_valid) + int'(done) + int'(load_ready), 0);
        // R3: samples offered while idle are not taken
        in_valid = 1'b1; in_re = 16'sh4000; in_im = 16'sh4000;
        repeat (2) @(negedge clk);
        in_valid = 1'b0;
        chk(load_ready == 1'b0, "R3", "in_valid ignored in idle", int'(load_ready), 0);

        run_frame(0, 1'b0, 1'b0);   // impulse: flat spectrum (R5, R6)
        run_frame(1, 1'b0, 1'b1);   // constant with stray start/in_valid (R2, R3)
        run_frame(2, 1'b1, 1'b0);   // single tone with input gaps (R3, R6)
        run_frame(3, 1'b0, 1'b0);   // shifted impulse: rotating phase, all twiddles (R5)

        chk(exp_q.size() == 0, "R7", "bins left over", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule